// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a synchronous user port and an asynchronous parallel static memory with active-low select, output-enable and write-enable inputs and a shared bidirectional data bus. One read or one write is issued per request. The block then moves the memory pins through a fixed series of phases. Each strobe phase lasts a whole number of clock cycles, and that number is derived at elaboration from nanosecond timing parameters and the clock period.

The user raises a one-cycle request together with a write flag, an address and write data. The block raises a one-cycle completion pulse once the memory is deselected again. For a read, the captured byte stays on the read-data output until a later read replaces it. Requests that arrive while a transfer is in progress are dropped.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: Read order. In the cycle after a request is accepted, the address is presented with all strobes high. Select goes low in the next cycle and output enable goes low in the cycle after that. Output enable stays low for ACC cycles and the bus is sampled at the end of the last of them. Output enable then rises, and select rises one cycle later.
- R2: Write order. In the cycle after acceptance, address and data are presented with all strobes high. Select goes low in the next cycle, then write enable goes low for WP cycles. Write enable then rises while select is still low, and select rises one cycle later.
- R3: Output enable is never low during a write. Output enable and write enable are never low together, and neither is ever low while select is high.
- R4: The block drives the data bus only from the address phase of a write through the cycle in which write enable rises. The driven value equals the request's write data. At all other times the block leaves the bus floating.
- R5: ACC = max(1, ceil(T_ACCESS_NS / CLK_PERIOD_NS)) and WP = max(1, ceil(T_WP_NS / CLK_PERIOD_NS)). The defaults are 70 ns, 40 ns and a 4 ns clock, which give ACC = 18 and WP = 10.
- R6: A request is taken only while the block is idle. A request raised during a transfer has no effect: no extra select cycle, no completion pulse and no memory write.
- R7: The completion pulse is high for exactly one cycle, which is the first cycle with select high again. Read data keeps its value until the next read completes.
- R8: Reset puts select, output enable and write enable high, floats the bus, clears the completion pulse and sets read data and the address to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Start one transfer (taken only when idle) |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Last read data |
| done_o | output | 1 | One-cycle completion pulse |
| sram_addr_o | output | ADDR_W | Memory address pins |
| sram_dq_io | inout | DATA_W | Memory data bus |
| sram_ce_n_o | output | 1 | Active-low chip select |
| sram_oe_n_o | output | 1 | Active-low output enable |
| sram_we_n_o | output | 1 | Active-low write enable |

## Verification
The hardest situation to reach is a write whose data is still held at the moment write enable rises. The bench's memory model stores the byte on that rising edge, so data released one cycle early would be stored as high impedance, and only a later read-back would show it. The stimulus therefore writes bytes and reads them back: random traffic over a small address window, plus walking-one and alternating-bit patterns at both address ends. A second request is also raised in the middle of a write to show that it is dropped.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_SELECT,
      ST_STROBE,
      ST_RELEASE,
      ST_FINISH
   } seq_state_t;

   typedef struct packed {
      logic ce_n;
      logic oe_n;
      logic we_n;
      logic drive;
      logic done;
   } pin_set_t;

   localparam pin_set_t PINS_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0, done: 1'b0};

   // Cycles for a phase of t_ns: rounded up, never below one.
   function automatic int unsigned phase_cycles(input int unsigned t_ns, input int unsigned period_ns);
      int unsigned c;
      c = (t_ns + period_ns - 1) / period_ns;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic pin_set_t pins_of(input seq_state_t s, input logic is_wr);
      pin_set_t p;
      p = PINS_IDLE;
      case (s)
         ST_SETUP:   p.drive = is_wr;
         ST_SELECT:  begin p.ce_n = 1'b0; p.drive = is_wr; end
         ST_STROBE:  begin
            p.ce_n  = 1'b0;
            p.oe_n  = is_wr;
            p.we_n  = ~is_wr;
            p.drive = is_wr;
         end
         ST_RELEASE: begin p.ce_n = 1'b0; p.drive = is_wr; end
         ST_FINISH:  p.done = 1'b1;
         default:    p = PINS_IDLE;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             last_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load_i)
         cnt_q <= load_val_i;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign last_o = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
   import sram_ctrl_pkg::*;
#(
   parameter int CNT_W    = 5,
   parameter int ACC_CYC  = 18,
   parameter int WP_CYC   = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic             we_i,
   input  logic             last_i,
   output seq_state_t       state_d_o,
   output logic             wr_d_o,
   output logic             accept_o,
   output logic             load_o,
   output logic [CNT_W-1:0] load_val_o,
   output logic             capture_o
);
   localparam logic [CNT_W-1:0] ACC_LOAD = CNT_W'(ACC_CYC - 1);
   localparam logic [CNT_W-1:0] WP_LOAD  = CNT_W'(WP_CYC - 1);

   seq_state_t state_q, state_d;
   logic       wr_q, wr_d;

   always_comb begin
      state_d    = state_q;
      wr_d       = wr_q;
      accept_o   = 1'b0;
      load_o     = 1'b0;
      load_val_o = '0;
      case (state_q)
         ST_IDLE: if (req_i) begin
            accept_o = 1'b1;
            wr_d     = we_i;
            state_d  = ST_SETUP;
         end
         ST_SETUP:   state_d = ST_SELECT;
         ST_SELECT: begin
            state_d    = ST_STROBE;
            load_o     = 1'b1;
            load_val_o = wr_q ? WP_LOAD : ACC_LOAD;
         end
         ST_STROBE:  if (last_i) state_d = ST_RELEASE;
         ST_RELEASE: state_d = ST_FINISH;
         ST_FINISH:  state_d = ST_IDLE;
         default:    state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         wr_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         wr_q    <= wr_d;
      end
   end

   assign state_d_o = state_d;
   assign wr_d_o    = wr_d;
   assign capture_o = (state_q == ST_STROBE) && !wr_q && last_i;
endmodule

// File: rtl/sram_dq_port.sv
module sram_dq_port #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              drive_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              capture_i,
   inout  wire  [DATA_W-1:0] dq_io,
   output logic [DATA_W-1:0] rdata_o
);
   assign dq_io = drive_i ? wdata_i : {DATA_W{1'bz}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata_o <= '0;
      else if (capture_i)
         rdata_o <= dq_io;
   end
endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W        = 15,
   parameter int DATA_W        = 8,
   parameter int CLK_PERIOD_NS = 4,
   parameter int T_ACCESS_NS   = 70,
   parameter int T_WP_NS       = 40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              done_o,
   output logic [ADDR_W-1:0] sram_addr_o,
   inout  wire  [DATA_W-1:0] sram_dq_io,
   output logic              sram_ce_n_o,
   output logic              sram_oe_n_o,
   output logic              sram_we_n_o
);
   localparam int ACC_CYC = int'(phase_cycles(T_ACCESS_NS, CLK_PERIOD_NS));
   localparam int WP_CYC  = int'(phase_cycles(T_WP_NS, CLK_PERIOD_NS));
   localparam int MAX_CYC = (ACC_CYC > WP_CYC) ? ACC_CYC : WP_CYC;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);

   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("sram_strobe_ctrl: ADDR_W and DATA_W must be at least 1");
   end
   if (CLK_PERIOD_NS < 1) begin : g_bad_period
      $error("sram_strobe_ctrl: CLK_PERIOD_NS must be at least 1");
   end

   seq_state_t       state_d;
   logic             wr_d, accept, load, last, capture;
   logic [CNT_W-1:0] load_val;
   pin_set_t         pins_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              dq_drive;

   sram_seq_fsm #(.CNT_W(CNT_W), .ACC_CYC(ACC_CYC), .WP_CYC(WP_CYC)) fsm_i (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .last_i(last),
      .state_d_o(state_d), .wr_d_o(wr_d), .accept_o(accept), .load_o(load),
      .load_val_o(load_val), .capture_o(capture)
   );

   sram_phase_timer #(.CNT_W(CNT_W)) timer_i (
      .clk(clk), .rst_n(rst_n), .load_i(load), .load_val_i(load_val), .last_o(last)
   );

   // Pins are registered from the next state so every strobe is a clean flop output.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pins_q  <= PINS_IDLE;
         addr_q  <= '0;
         wdata_q <= '0;
      end else begin
         pins_q <= pins_of(state_d, wr_d);
         if (accept) begin
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
         end
      end
   end

   assign dq_drive = pins_q.drive;

   sram_dq_port #(.DATA_W(DATA_W)) dq_i (
      .clk(clk), .rst_n(rst_n), .drive_i(dq_drive), .wdata_i(wdata_q),
      .capture_i(capture), .dq_io(sram_dq_io), .rdata_o(rdata_o)
   );

   assign sram_addr_o = addr_q;
   assign sram_ce_n_o = pins_q.ce_n;
   assign sram_oe_n_o = pins_q.oe_n;
   assign sram_we_n_o = pins_q.we_n;
   assign done_o      = pins_q.done;
endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
module sram_strobe_ctrl_chk #(
   parameter int ADDR_W  = 15,
   parameter int DATA_W  = 8,
   parameter int ACC_CYC = 18,
   parameter int WP_CYC  = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_n,
   input logic              oe_n,
   input logic              we_n,
   input logic              done,
   input logic              drive,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] dq
);
   logic [15:0] oe_low_cnt, we_low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_low_cnt <= '0;
         we_low_cnt <= '0;
      end else begin
         oe_low_cnt <= oe_n ? 16'd0 : oe_low_cnt + 16'd1;
         we_low_cnt <= we_n ? 16'd0 : we_low_cnt + 16'd1;
      end
   end

   a_r3_oe_we_exclusive: assert property (@(posedge clk) disable iff (!rst_n) !(!oe_n && !we_n));
   a_r3_oe_needs_ce:     assert property (@(posedge clk) disable iff (!rst_n) !oe_n |-> !ce_n);
   a_r3_no_drive_on_oe:  assert property (@(posedge clk) disable iff (!rst_n) !oe_n |-> !drive);
   a_r2_we_needs_ce:     assert property (@(posedge clk) disable iff (!rst_n) !we_n |-> !ce_n);
   a_r2_ce_after_we:     assert property (@(posedge clk) disable iff (!rst_n) $rose(we_n) |-> !ce_n);
   a_r4_data_held:       assert property (@(posedge clk) disable iff (!rst_n) $rose(we_n) |-> (drive && $stable(dq)));
   a_r1_addr_stable:     assert property (@(posedge clk) disable iff (!rst_n) $fell(ce_n) |-> $stable(addr));
   a_r5_acc_width:       assert property (@(posedge clk) disable iff (!rst_n) $rose(oe_n) |-> (oe_low_cnt == 16'(ACC_CYC)));
   a_r5_wp_width:        assert property (@(posedge clk) disable iff (!rst_n) $rose(we_n) |-> (we_low_cnt == 16'(WP_CYC)));
   a_r7_done_single:     assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
   a_r7_done_after_ce:   assert property (@(posedge clk) disable iff (!rst_n) done |-> (ce_n && $past(!ce_n)));
endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACC_CYC(ACC_CYC), .WP_CYC(WP_CYC)
) chk_i (
   .clk(clk), .rst_n(rst_n), .ce_n(sram_ce_n_o), .oe_n(sram_oe_n_o), .we_n(sram_we_n_o),
   .done(done_o), .drive(dq_drive), .addr(sram_addr_o), .dq(sram_dq_io)
);

// File: tb/sram_strobe_ctrl_tb_top.sv
module sram_strobe_ctrl_tb_top;
   localparam int AW = 15;
   localparam int DW = 8;

   function automatic int ceil_min1(input int t, input int p);
      int c;
      c = (t + p - 1) / p;
      return (c < 1) ? 1 : c;
   endfunction
   localparam int EXP_ACC = ceil_min1(70, 4);
   localparam int EXP_WP  = ceil_min1(40, 4);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req = 1'b0, we = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          done;
   logic [AW-1:0] s_addr;
   wire  [DW-1:0] s_dq;
   logic          s_ce_n, s_oe_n, s_we_n;

   int tests = 0, fails = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   sram_strobe_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
      .rdata_o(rdata), .done_o(done), .sram_addr_o(s_addr), .sram_dq_io(s_dq),
      .sram_ce_n_o(s_ce_n), .sram_oe_n_o(s_oe_n), .sram_we_n_o(s_we_n)
   );

   // ---------------- memory model ----------------
   logic [DW-1:0] model_mem [int];
   logic [DW-1:0] ref_mem [int];
   logic [DW-1:0] model_q;
   int            mem_gen = 0;

   function automatic logic [DW-1:0] dflt(input logic [AW-1:0] a);
      return a[7:0] ^ {1'b0, a[14:8]};
   endfunction

   always @(s_addr or mem_gen) begin
      if (model_mem.exists(int'(s_addr))) model_q = model_mem[int'(s_addr)];
      else model_q = dflt(s_addr);
   end

   assign s_dq = (!s_ce_n && !s_oe_n && s_we_n) ? model_q : {DW{1'bz}};

   always @(posedge s_we_n) begin
      if (s_ce_n === 1'b0) begin
         model_mem[int'(s_addr)] = s_dq;
         mem_gen = mem_gen + 1;
      end
   end

   // ---------------- check helper ----------------
   task automatic check(input string req_tag, input logic [31:0] got, input logic [31:0] exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req_tag, got, exp);
      end
   endtask

   // ---------------- timing monitor ----------------
   int  cyc = 0;
   int  t_ce_fall = -1000, t_ce_rise = -1000, t_oe_fall = -1000, t_oe_rise = -1000;
   int  t_we_fall = -1000, t_we_rise = -1000;
   logic p_ce = 1, p_oe = 1, p_we = 1, p_done = 0;
   bit   cur_wr = 0;
   logic [DW-1:0] cur_wdata = '0;
   int   ce_falls = 0, done_cnt = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         cyc++;
         if (p_ce && !s_ce_n) begin t_ce_fall = cyc; ce_falls++; end
         if (!p_ce && s_ce_n) t_ce_rise = cyc;
         if (p_oe && !s_oe_n) t_oe_fall = cyc;
         if (!p_oe && s_oe_n) t_oe_rise = cyc;
         if (p_we && !s_we_n) t_we_fall = cyc;
         if (!p_we && s_we_n) begin
            t_we_rise = cyc;
            check("R4 data driven at WE rise", 32'(s_dq), 32'(cur_wdata));
         end
         if (!s_oe_n && (!s_we_n || cur_wr)) check("R3 OE low in write", 32'(s_oe_n), 32'd1);
         if (p_done) check("R7 done one cycle", 32'(done), 32'd0);
         if (done) begin
            done_cnt++;
            check("R7 CE high with done", 32'(s_ce_n), 32'd1);
            check("R4 bus floating at done", 32'(s_dq === {DW{1'bz}}), 32'd1);
            if (cur_wr) begin
               check("R2 CE rise", 32'(t_ce_rise), 32'(cyc));
               check("R2 WE rise", 32'(t_we_rise), 32'(cyc - 1));
               check("R5 WE width", 32'(t_we_rise - t_we_fall), 32'(EXP_WP));
               check("R2 CE fall", 32'(t_ce_fall), 32'(t_we_fall - 1));
            end else begin
               check("R1 CE rise", 32'(t_ce_rise), 32'(cyc));
               check("R1 OE rise", 32'(t_oe_rise), 32'(cyc - 1));
               check("R5 OE width", 32'(t_oe_rise - t_oe_fall), 32'(EXP_ACC));
               check("R1 CE fall", 32'(t_ce_fall), 32'(t_oe_fall - 1));
            end
         end
         p_ce = s_ce_n; p_oe = s_oe_n; p_we = s_we_n; p_done = done;
      end
   end

   // ---------------- transactions ----------------
   task automatic do_op(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
      logic [DW-1:0] exp;
      @(negedge clk);
      req = 1'b1; we = w; addr = a; wdata = d;
      cur_wr = w; cur_wdata = d;
      @(negedge clk);
      req = 1'b0;
      check(w ? "R2 address presented" : "R1 address presented", 32'(s_addr), 32'(a));
      check(w ? "R2 strobes high in setup" : "R1 strobes high in setup",
            32'({s_ce_n, s_oe_n, s_we_n}), 32'b111);
      if (w) check("R4 data driven in setup", 32'(s_dq), 32'(d));
      do @(negedge clk); while (!done);
      if (w) ref_mem[int'(a)] = d;
      else begin
         exp = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : dflt(a);
         check("R1 read data", 32'(rdata), 32'(exp));
      end
   endtask

   initial begin
      logic [DW-1:0] held;
      int falls_before, done_before;
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      // R8 reset state
      check("R8 strobes high", 32'({s_ce_n, s_oe_n, s_we_n}), 32'b111);
      check("R8 done low", 32'(done), 32'd0);
      check("R8 rdata zero", 32'(rdata), 32'd0);
      check("R8 addr zero", 32'(s_addr), 32'd0);
      check("R8 bus floating", 32'(s_dq === {DW{1'bz}}), 32'd1);
      rst_n = 1'b1;
      check("R5 expected ACC", 32'(EXP_ACC), 32'd18);
      check("R5 expected WP", 32'(EXP_WP), 32'd10);

      // Unwritten read, boundary addresses
      do_op(1'b0, 15'h0000, 8'h00);
      do_op(1'b0, 15'h7FFF, 8'h00);
      // Walking ones and alternating patterns at both ends
      for (int i = 0; i < 8; i++) do_op(1'b1, AW'(i), 8'(1 << i));
      for (int i = 0; i < 8; i++) do_op(1'b0, AW'(i), 8'h00);
      do_op(1'b1, 15'h7FFF, 8'hAA);
      do_op(1'b1, 15'h7FFE, 8'h55);
      do_op(1'b0, 15'h7FFF, 8'h00);
      do_op(1'b0, 15'h7FFE, 8'h00);

      // R7: read data held across a later write
      held = rdata;
      do_op(1'b1, 15'h0100, 8'hC3);
      check("R7 rdata held over write", 32'(rdata), 32'(held));

      // R6: request while busy is dropped
      @(negedge clk);
      req = 1'b1; we = 1'b1; addr = 15'h0200; wdata = 8'h3C;
      cur_wr = 1'b1; cur_wdata = 8'h3C;
      @(negedge clk);
      req = 1'b0;
      falls_before = ce_falls;
      done_before  = done_cnt;
      repeat (4) @(negedge clk);
      req = 1'b1; we = 1'b1; addr = 15'h0300; wdata = 8'hE7;
      @(negedge clk);
      req = 1'b0;
      check("R6 address not changed", 32'(s_addr), 32'h0200);
      do @(negedge clk); while (!done);
      ref_mem[32'h0200] = 8'h3C;
      repeat (6) @(negedge clk);
      check("R6 no extra select", 32'(ce_falls - falls_before), 32'd1);
      check("R6 no extra done", 32'(done_cnt - done_before), 32'd1);
      do_op(1'b0, 15'h0300, 8'h00);
      do_op(1'b0, 15'h0200, 8'h00);

      // Random traffic over a small window so reads hit earlier writes
      for (int n = 0; n < 160; n++) begin
         logic [AW-1:0] ra;
         ra = AW'(15'h1000 + ($urandom % 24));
         do_op(1'($urandom), ra, 8'($urandom));
      end

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule